// File: doc/BRIEF.md
# DRAM bank state tracker

This block sits beside a memory controller and watches every command it sends to a DRAM with several banks. It keeps one open/idle bit per bank. A legal ACTIVATE sets the bit, and a PRECHARGE clears either one bit or all of them. It rejects any command that the current bank state does not allow. A rejected command leaves the state untouched and raises a one-cycle error pulse.

A loadable countdown models the row-precharge recovery time. It restarts on every PRECHARGE, and its length comes from a configuration input. A second countdown covers the data burst that follows each accepted READ or WRITE. REFRESH and self-refresh entry are accepted only when the whole device is quiet. The all-idle output tells the controller when that condition holds.

Command codes on `cmd_op`: 0 no-op, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 self-refresh entry, 7 reserved. Bank `i` is bit `i` of `bank_open_o`.

Top module: `dram_bank_tracker`

## Requirements
- R1: While reset is asserted and after it is released, `bank_open_o` is all zero, `all_idle_o` is 1 and `err_o` is 0. The precharge countdown starts out expired.
- R2: An ACTIVATE (code 1) to an idle bank sets that bank's bit after the clock edge that accepts it and does not raise `err_o`.
- R3: An ACTIVATE to a bank that is already open raises `err_o` for the single following cycle. It changes no bank bit.
- R4: A READ (code 2) or WRITE (code 3) to an idle bank raises `err_o` for one cycle and changes no bank bit. To an open bank it is accepted without error.
- R5: A PRECHARGE (code 4) with `cmd_a10` = 0 clears only the bit of the bank on `cmd_ba` and never raises `err_o`.
- R6: A PRECHARGE with `cmd_a10` = 1 clears every bank bit, whatever value `cmd_ba` holds.
- R7: Every PRECHARGE loads the countdown with `cfg_trp`. `all_idle_o` is 1 only when no bank is open and the countdown has reached zero, which happens `cfg_trp` cycles after the PRECHARGE edge. A value of 0 means no wait.
- R8: Self-refresh entry (code 6) is accepted only when `all_idle_o` is 1 and no burst is running. A burst is running for `BURST_CYC` cycles after an accepted READ or WRITE. Otherwise the command raises `err_o`. The command never changes bank bits.
- R9: REFRESH (code 5) is accepted only when `all_idle_o` is 1. Otherwise it raises `err_o`. It never changes bank bits.
- R10: When `cmd_vld` is 0, the command inputs are ignored: bank bits stay unchanged and `err_o` stays 0.
- R11: The reserved code 7 with `cmd_vld` = 1 always raises `err_o` and changes no bank bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_vld | input | 1 | Command strobe; the other command inputs count only when it is high |
| cmd_op | input | 3 | Command code (see list above) |
| cmd_ba | input | BA_W (3) | Bank address |
| cmd_a10 | input | 1 | Address bit 10; selects the all-bank form of PRECHARGE |
| cfg_trp | input | TRP_W (8) | Precharge recovery length in cycles |
| bank_open_o | output | NUM_BANKS (8) | One bit per bank, 1 = open |
| all_idle_o | output | 1 | No bank open and precharge recovery elapsed |
| err_o | output | 1 | One-cycle pulse after a rejected command |

## Verification
The bench builds the tracker with the default eight banks and a short burst length of 3. This keeps the burst countdown and its expiry within a few cycles of each test command. It sweeps every bank through the open, reopen, access and single-bank-close sequence. It also repeats the precharge-to-self-refresh race for several `cfg_trp` values, including 0, so that the edge where the recovery countdown lets the entry through is reached for each one.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_SRE = 3'd6,
    OP_RSV = 3'd7
  } dbt_op_e;
endpackage

// File: rtl/dbt_down_timer.sv
module dbt_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  p_load_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));
endmodule

// File: rtl/dbt_rule_check.sv
module dbt_rule_check
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BA_W = 3
) (
  input  logic                 vld_i,
  input  dbt_op_e              op_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic                 dev_idle_i,
  input  logic                 burst_idle_i,
  output logic                 err_det_o,
  output logic [NUM_BANKS-1:0] set_o,
  output logic [NUM_BANKS-1:0] clr_o,
  output logic                 ld_trp_o,
  output logic                 ld_burst_o
);
  logic [NUM_BANKS-1:0] sel;
  logic                 tgt_open;
  logic                 legal;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign sel[i] = (ba_i == BA_W'(i));
  end

  assign tgt_open = |(open_i & sel);

  always_comb begin
    legal      = 1'b1;
    set_o      = '0;
    clr_o      = '0;
    ld_trp_o   = 1'b0;
    ld_burst_o = 1'b0;
    if (vld_i) begin
      case (op_i)
        OP_NOP: legal = 1'b1;
        OP_ACT: begin
          legal = !tgt_open;
          if (!tgt_open) set_o = sel;
        end
        OP_RD, OP_WR: begin
          legal      = tgt_open;
          ld_burst_o = tgt_open;
        end
        OP_PRE: begin
          clr_o    = a10_i ? {NUM_BANKS{1'b1}} : sel;
          ld_trp_o = 1'b1;
        end
        OP_REF:  legal = dev_idle_i;
        OP_SRE:  legal = dev_idle_i && burst_idle_i;
        default: legal = 1'b0;
      endcase
    end
  end

  assign err_det_o = vld_i && !legal;
endmodule

// File: rtl/dbt_bank_array.sv
module dbt_bank_array #(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] set_i,
  input  logic [NUM_BANKS-1:0] clr_i,
  output logic [NUM_BANKS-1:0] open_o
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic open_q, open_d, open_en;

    always_comb begin
      open_en = set_i[i] || clr_i[i];
      open_d  = set_i[i] && !clr_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_q <= 1'b0;
      else if (open_en) open_q <= open_d;
    end

    assign open_o[i] = open_q;

    p_mask_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_i[i] && clr_i[i]));
  end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TRP_W     = 8,
  parameter int BURST_CYC = 4,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int BST_W    = $clog2(BURST_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_vld,
  input  logic [2:0]           cmd_op,
  input  logic [BA_W-1:0]      cmd_ba,
  input  logic                 cmd_a10,
  input  logic [TRP_W-1:0]     cfg_trp,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 all_idle_o,
  output logic                 err_o
);
  logic [1:0]           rst_sync_q;
  logic                 rst_i_n;
  dbt_op_e              op;
  logic [NUM_BANKS-1:0] set_m, clr_m;
  logic                 ld_trp, ld_burst, trp_zero, burst_zero;
  logic                 err_det, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign op = dbt_op_e'(cmd_op);

  dbt_rule_check #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_rules (
    .vld_i       (cmd_vld),
    .op_i        (op),
    .ba_i        (cmd_ba),
    .a10_i       (cmd_a10),
    .open_i      (bank_open_o),
    .dev_idle_i  (all_idle_o),
    .burst_idle_i(burst_zero),
    .err_det_o   (err_det),
    .set_o       (set_m),
    .clr_o       (clr_m),
    .ld_trp_o    (ld_trp),
    .ld_burst_o  (ld_burst)
  );

  dbt_bank_array #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (set_m),
    .clr_i (clr_m),
    .open_o(bank_open_o)
  );

  dbt_down_timer #(.W(TRP_W)) u_trp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load_i    (ld_trp),
    .load_val_i(cfg_trp),
    .zero_o    (trp_zero)
  );

  dbt_down_timer #(.W(BST_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load_i    (ld_burst),
    .load_val_i(BST_W'(BURST_CYC)),
    .zero_o    (burst_zero)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) err_q <= 1'b0;
    else          err_q <= err_det;
  end

  assign err_o      = err_q;
  assign all_idle_o = (bank_open_o == '0) && trp_zero;

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_vld && op == OP_ACT && !bank_open_o[cmd_ba]) |=> bank_open_o[$past(cmd_ba)] && !err_o);
  p_err_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_o |-> bank_open_o == $past(bank_open_o));
  p_rdwr_idle_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_vld && (op == OP_RD || op == OP_WR) && !bank_open_o[cmd_ba]) |=> err_o);
  p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_vld && op == OP_PRE && cmd_a10) |=> bank_open_o == '0);
  p_sre_burst_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_vld && op == OP_SRE && !burst_zero) |=> err_o);
  p_ref_busy_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_vld && op == OP_REF && !all_idle_o) |=> err_o);
  p_no_vld_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cmd_vld |=> ($stable(bank_open_o) && !err_o));
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_vld && op == OP_RSV) |=> err_o);
endmodule

// File: tb/dram_bank_tracker_bench.sv
module dram_bank_tracker_bench;
  localparam int NB    = 8;
  localparam int BURST = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_vld;
  logic [2:0] cmd_op;
  logic [2:0] cmd_ba;
  logic       cmd_a10;
  logic [7:0] cfg_trp;
  logic [NB-1:0] bank_open_o;
  logic       all_idle_o, err_o;

  int n_chk = 0, n_fail = 0;
  logic [NB-1:0] m_open;
  int m_trp, m_burst;
  logic exp_err;

  always #10 clk = ~clk;

  dram_bank_tracker #(.NUM_BANKS(NB), .TRP_W(8), .BURST_CYC(BURST)) u_dram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_ba(cmd_ba),
    .cmd_a10(cmd_a10), .cfg_trp(cfg_trp), .bank_open_o(bank_open_o),
    .all_idle_o(all_idle_o), .err_o(err_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, predict, then compare at the next falling edge.
  task automatic step(input string tag, input logic vld, input int op, input int ba, input logic a10);
    logic legal;
    logic idle;
    cmd_vld = vld; cmd_op = 3'(op); cmd_ba = 3'(ba); cmd_a10 = a10;
    idle  = (m_open == '0) && (m_trp == 0);
    legal = 1'b1;
    if (vld) begin
      case (op)
        1: legal = !m_open[ba];
        2, 3: legal = m_open[ba];
        5: legal = idle;
        6: legal = idle && (m_burst == 0);
        7: legal = 1'b0;
        default: legal = 1'b1;
      endcase
    end
    exp_err = vld && !legal;
    @(posedge clk);
    if (m_trp > 0) m_trp--;
    if (m_burst > 0) m_burst--;
    if (vld && legal) begin
      if (op == 1) m_open[ba] = 1'b1;
      if (op == 2 || op == 3) m_burst = BURST;
      if (op == 4) begin
        if (a10) m_open = '0; else m_open[ba] = 1'b0;
        m_trp = int'(cfg_trp);
      end
    end
    @(negedge clk);
    cmd_vld = 1'b0;
    check(tag, "bank_open", int'(bank_open_o), int'(m_open));
    check(tag, "err", int'(err_o), int'(exp_err));
    check(tag, "all_idle", int'(all_idle_o), int'((m_open == '0) && (m_trp == 0)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_op = '0; cmd_ba = '0; cmd_a10 = 1'b0; cfg_trp = 8'd2;
    m_open = '0; m_trp = 0; m_burst = 0;
    #1;
    check("R1", "open in reset", int'(bank_open_o), 0);
    check("R1", "err in reset", int'(err_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "open after reset", int'(bank_open_o), 0);
    check("R1", "idle after reset", int'(all_idle_o), 1);
    check("R1", "err after reset", int'(err_o), 0);

    // Per-bank sweep
    for (int b = 0; b < NB; b++) begin
      step("R2", 1, 1, b, 0);
      step("R3", 1, 1, b, 0);
      step("R4", 1, 2, b, 0);
      step("R4", 1, 3, b, 0);
      step("R4", 1, 3, (b + 1) % NB, 0);
      step("R4", 1, 2, (b + 1) % NB, 0);
      step("R5", 1, 4, b, 0);
      step("R5", 1, 4, b, 0);
    end
    // Single-bank close leaves neighbours open
    for (int b = 0; b < NB; b++) step("R2", 1, 1, b, 0);
    step("R5", 1, 4, 6, 0);
    step("R10", 0, 1, 6, 0);
    step("R10", 0, 4, 0, 1);
    step("R11", 1, 7, 2, 1);
    step("R9", 1, 5, 0, 0);
    step("R8", 1, 6, 0, 0);
    cfg_trp = 8'd3;
    step("R6", 1, 4, 5, 1);
    for (int k = 0; k < 4; k++) step("R7", 1, 5, 0, 0);

    // Recovery length sweep against self-refresh entry
    for (int t = 0; t < 6; t++) begin
      cfg_trp = 8'(t);
      step("R2", 1, 1, t, 0);
      step("R5", 1, 4, t, 0);
      for (int k = 0; k < t + 2; k++) step("R8", 1, 6, 0, 0);
    end

    // Burst blocks self-refresh entry after the banks close
    cfg_trp = 8'd0;
    for (int g = 0; g < 4; g++) begin
      step("R2", 1, 1, 2, 0);
      step("R4", 1, 2 + (g % 2), 2, 0);
      for (int w = 0; w < g; w++) step("R8", 0, 0, 0, 0);
      step("R6", 1, 4, 0, 1);
      for (int k = 0; k < BURST + 1; k++) step("R8", 1, 6, 0, 0);
    end
    step("R9", 1, 5, 3, 0);
    step("R11", 1, 7, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule